// File: doc/BRIEF.md
# Preamble Double-Correlation Timing Synchronizer

This block finds the start of a packet in a stream of signed complex baseband samples arriving at 20 MHz. Two correlators run side by side on every accepted sample.

- **Periodicity correlator.** It measures how well the signal matches itself 16 samples earlier, which exposes the repeating short training sequence. It gives a coarse indication that a packet is present.
- **Pattern correlator.** It matches the last 16 samples against a stored, sign-quantized copy of one short training period. It gives the exact position of the symbol boundary.

Detection runs in two steps. A sustained periodicity detection raises a one-cycle frame-detected pulse and opens a search window. Within that window the strongest pattern match above a programmable threshold fixes the timing. From then on the block emits a boundary strobe every 80 samples, which is one OFDM frame of 16 prefix chips plus 64 payload chips.

The running periodicity sum is also driven out on every sample, for use by a downstream frequency-offset estimator. Sampling-clock drift is small enough to be ignored, so once locked the block keeps its timing until reset.

Top module: `psync_top`

## Requirements
- R1: While rst_n is sampled low, and on the cycle after it is released, frame_det and sym_strobe are 0 and acorr_re/acorr_im are 0. All sample history counts as zero.
- R2: One cycle after an accepted sample n (in_valid high at a rising edge), acorr equals the sum over i = n-15..n of r[i]·conj(r[i-16]). Samples older than reset count as zero.
- R3: A cycle with in_valid low changes no state. acorr holds its value, no pulse is produced, and the boundary count does not advance.
- R4: An accepted sample is a periodicity hit when 256·|acorr|² > det_frac·E², where E is the sum of |r[i]|² over the 16 most recent samples including the current one.
- R5: While idle, when hits have occurred on 8 consecutive accepted samples, frame_det pulses high for one cycle, in the cycle after the 8th hit. A non-hit sample restarts the run.
- R6: The match metric for sample n is |Xre|+|Xim|, where X = sum over k = 0..15 of r[n-15+k]·conj(c[k]). The code c[k] sits in bits [2k+1:2k] of the COEF parameter (default 32'hB4E12D78), and codes 0, 1, 2 and 3 mean +1, +j, -1 and -j.
- R7: The search covers the 64 accepted samples that follow the detecting sample. The peak is the sample with the largest metric strictly above xc_thresh. On equal metrics the earliest such sample is the peak, and the 64th sample still competes.
- R8: If no sample in the search window exceeds xc_thresh, the block returns to idle after the 64th sample, and its hit run starts from zero with the next sample.
- R9: With peak sample p, sym_strobe pulses for one cycle after samples p+80, p+160, p+240 and so on. Sample positions are counted in accepted samples.
- R10: After a frame_det pulse, no further frame_det occurs during search or lock. Periodicity hits in those states have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe; high when in_re/in_im carry a sample |
| in_re | input | 8 | Real part, two's complement |
| in_im | input | 8 | Imaginary part, two's complement |
| det_frac | input | 8 | Periodicity threshold, in units of 1/256 |
| xc_thresh | input | 13 | Minimum match metric for a fine-timing peak |
| frame_det | output | 1 | One-cycle pulse on coarse packet detection |
| sym_strobe | output | 1 | One-cycle pulse at each symbol boundary |
| acorr_re | output | 21 | Real part of the running periodicity sum |
| acorr_im | output | 21 | Imaginary part of the running periodicity sum |

## Verification
The two functions that can fall on the same accepted sample are peak selection and the closing of the search window. This happens when the 64th search sample is also the strongest match, so that sample must both update the peak and decide between lock and idle.

The bench provokes this case directly. It feeds a non-matching periodic pattern until detection, then 48 zero samples, then the exact stored pattern, so that the full match lands on search sample 64. The only correct outcome is a first boundary strobe 80 samples after that sample.

A second coincidence is driven by keeping the periodic preamble going through search and lock. Hits then keep arriving while a frame is already detected, and frame_det must stay silent. The bench compares every cycle against its own sample-level model.

// File: rtl/psync_pkg.sv
// Shared types for the preamble timing synchronizer.
package psync_pkg;
    // Control phases: waiting for periodicity, searching for a peak, locked.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LOCK   = 2'd2
    } psync_state_e;
endpackage

// File: rtl/psync_acorr.sv
// Moving delayed autocorrelation and window energy.
// Keeps LAG past samples, plus LAG past products and powers, so that each
// running sum is updated by one add and one subtract per accepted sample.
// Assumes LAG is a power of two. Exposes the sample history for the
// pattern correlator.
module psync_acorr #(
    parameter int W   = 8,
    parameter int LAG = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic signed [W-1:0]         in_re,
    input  logic signed [W-1:0]         in_im,
    output logic [LAG-1:0][2*W-1:0]     hist,
    output logic signed [2*W+$clog2(LAG):0] a_re_nxt,
    output logic signed [2*W+$clog2(LAG):0] a_im_nxt,
    output logic [2*W+$clog2(LAG):0]    e_nxt,
    output logic signed [2*W+$clog2(LAG):0] a_re_q,
    output logic signed [2*W+$clog2(LAG):0] a_im_q
);
    localparam int LW = $clog2(LAG);
    localparam int PW = 2*W + 1;
    localparam int AW = PW + LW;

    logic [LAG-1:0][2*W-1:0]  hist_q;
    logic [LAG-1:0][2*PW-1:0] prod_q;
    logic [LAG-1:0][PW-1:0]   pow_q;
    logic [AW-1:0]            en_q;
    logic signed [W-1:0]      old_re, old_im;
    logic signed [PW-1:0]     p_re, p_im, lv_re, lv_im;
    logic [PW-1:0]            pw;

    assign old_re = hist_q[LAG-1][2*W-1:W];
    assign old_im = hist_q[LAG-1][W-1:0];
    assign lv_re  = prod_q[LAG-1][2*PW-1:PW];
    assign lv_im  = prod_q[LAG-1][PW-1:0];
    assign hist   = hist_q;

    // Newest lag product r[n]*conj(r[n-LAG]) and newest sample power.
    always_comb begin
        p_re = PW'(in_re) * PW'(old_re) + PW'(in_im) * PW'(old_im);
        p_im = PW'(in_im) * PW'(old_re) - PW'(in_re) * PW'(old_im);
        pw   = PW'(in_re) * PW'(in_re) + PW'(in_im) * PW'(in_im);
    end

    // Running sums after this sample: the newest term enters, the oldest leaves.
    assign a_re_nxt = a_re_q + AW'(p_re) - AW'(lv_re);
    assign a_im_nxt = a_im_q + AW'(p_im) - AW'(lv_im);
    assign e_nxt    = en_q + AW'(pw) - AW'(pow_q[LAG-1]);

    // Shift the histories and commit the sums on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            prod_q <= '0;
            pow_q  <= '0;
            a_re_q <= '0;
            a_im_q <= '0;
            en_q   <= '0;
        end else if (in_valid) begin
            hist_q <= {hist_q[LAG-2:0], {in_re, in_im}};
            prod_q <= {prod_q[LAG-2:0], {p_re, p_im}};
            pow_q  <= {pow_q[LAG-2:0], pw};
            a_re_q <= a_re_nxt;
            a_im_q <= a_im_nxt;
            en_q   <= e_nxt;
        end
    end

    // R3: an idle input cycle leaves the published sum untouched.
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(a_re_q) && $stable(a_im_q)));
endmodule

// File: rtl/psync_xcorr.sv
// Sign-quantized cross-correlator against one stored training period.
// Each coefficient is +1, +j, -1 or -j, so every tap is a swap and/or
// negation, with no multiplier. Output is the L1 magnitude of the sum.
// Assumes hist[0] holds the sample just before the current one.
module psync_xcorr #(
    parameter int           W    = 8,
    parameter int           LAG  = 16,
    parameter logic [2*LAG-1:0] COEF = '0
) (
    input  logic signed [W-1:0]     in_re,
    input  logic signed [W-1:0]     in_im,
    input  logic [LAG-1:0][2*W-1:0] hist,
    output logic [W+$clog2(LAG):0]  metric
);
    localparam int MW = W + 1 + $clog2(LAG);

    logic [LAG-1:0][2*W+1:0] rot;
    logic signed [MW-1:0]    s_re, s_im;
    logic [MW-1:0]           m_re, m_im;

    // Multiply one sample by the conjugate of a unit-axis coefficient.
    function automatic logic [2*W+1:0] conj_rot(input logic signed [W-1:0] a,
                                                input logic signed [W-1:0] b,
                                                input logic [1:0] code);
        logic signed [W:0] xa, xb;
        xa = (W+1)'(a);
        xb = (W+1)'(b);
        case (code)
            2'd0:    conj_rot = {xa, xb};
            2'd1:    conj_rot = {xb, -xa};
            2'd2:    conj_rot = {-xa, -xb};
            default: conj_rot = {-xb, xa};
        endcase
    endfunction

    // Tap k meets sample r[n-LAG+1+k]; the last tap takes the live sample.
    for (genvar k = 0; k < LAG; k++) begin : g_tap
        if (k == LAG-1) begin : g_cur
            assign rot[k] = conj_rot(in_re, in_im, COEF[2*k +: 2]);
        end else begin : g_old
            assign rot[k] = conj_rot(hist[LAG-2-k][2*W-1:W], hist[LAG-2-k][W-1:0],
                                     COEF[2*k +: 2]);
        end
    end

    // Sum the rotated taps and form |re|+|im|.
    always_comb begin
        s_re = '0;
        s_im = '0;
        for (int k = 0; k < LAG; k++) begin
            s_re = s_re + MW'($signed(rot[k][2*W+1:W+1]));
            s_im = s_im + MW'($signed(rot[k][W:0]));
        end
        m_re   = s_re[MW-1] ? -s_re : s_re;
        m_im   = s_im[MW-1] ? -s_im : s_im;
        metric = m_re + m_im;
    end
endmodule

// File: rtl/psync_ctrl.sv
// Detection and timing controller.
// Counts consecutive periodicity hits, searches a fixed window for the
// strongest pattern match, then counts out frame boundaries.
// Assumes PERIOD >= SEARCH, so the first boundary lies after the window.
module psync_ctrl
    import psync_pkg::*;
#(
    parameter int AW     = 21,
    parameter int MW     = 13,
    parameter int FW     = 8,
    parameter int HOLD   = 8,
    parameter int SEARCH = 64,
    parameter int PERIOD = 80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [AW-1:0] a_re_nxt,
    input  logic signed [AW-1:0] a_im_nxt,
    input  logic [AW-1:0]        e_nxt,
    input  logic [MW-1:0]        metric,
    input  logic [FW-1:0]        det_frac,
    input  logic [MW-1:0]        xc_thresh,
    output logic                 frame_det,
    output logic                 sym_strobe
);
    localparam int CW = 2*AW + FW + 2;
    localparam int RW = $clog2(HOLD + 1);
    localparam int SW = $clog2(SEARCH + 1);
    localparam int TW = $clog2(PERIOD + 1);

    psync_state_e         state_q;
    logic [RW-1:0]        run_q, run_nxt;
    logic [SW-1:0]        scnt_q, k_nxt, boff_q, off_c;
    logic [MW-1:0]        best_q;
    logic                 found_q, found_c, take, hit;
    logic [TW-1:0]        pcnt_q;
    logic signed [CW-1:0] ar_x, ai_x, e_x, f_x, lhs, rhs;

    // Periodicity test: 2^FW * |A|^2 against det_frac * E^2.
    always_comb begin
        ar_x = CW'(a_re_nxt);
        ai_x = CW'(a_im_nxt);
        e_x  = CW'(e_nxt);
        f_x  = CW'(det_frac);
        lhs  = (ar_x * ar_x + ai_x * ai_x) <<< FW;
        rhs  = f_x * e_x * e_x;
        hit  = lhs > rhs;
    end

    // Peak candidate for the current search sample.
    always_comb begin
        run_nxt = run_q + RW'(1);
        k_nxt   = scnt_q + SW'(1);
        take    = (metric > xc_thresh) && (!found_q || metric > best_q);
        off_c   = take ? k_nxt : boff_q;
        found_c = found_q || take;
    end

    // Phase sequencing, pulse generation and boundary counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            run_q      <= '0;
            scnt_q     <= '0;
            boff_q     <= '0;
            best_q     <= '0;
            found_q    <= 1'b0;
            pcnt_q     <= '0;
            frame_det  <= 1'b0;
            sym_strobe <= 1'b0;
        end else begin
            frame_det  <= 1'b0;
            sym_strobe <= 1'b0;
            if (in_valid) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (!hit) begin
                            run_q <= '0;
                        end else if (run_nxt == RW'(HOLD)) begin
                            frame_det <= 1'b1;
                            state_q   <= ST_SEARCH;
                            run_q     <= '0;
                            scnt_q    <= '0;
                            found_q   <= 1'b0;
                            best_q    <= '0;
                            boff_q    <= '0;
                        end else begin
                            run_q <= run_nxt;
                        end
                    end
                    ST_SEARCH: begin
                        if (take) best_q <= metric;
                        found_q <= found_c;
                        boff_q  <= off_c;
                        if (k_nxt == SW'(SEARCH)) begin
                            scnt_q <= '0;
                            if (found_c) begin
                                state_q <= ST_LOCK;
                                pcnt_q  <= TW'(off_c) + TW'(PERIOD - SEARCH);
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            scnt_q <= k_nxt;
                        end
                    end
                    ST_LOCK: begin
                        if (pcnt_q == TW'(1)) begin
                            sym_strobe <= 1'b1;
                            pcnt_q     <= TW'(PERIOD);
                        end else begin
                            pcnt_q <= pcnt_q - TW'(1);
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R5: the detection pulse lasts one cycle.
    p_det_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_det |=> !frame_det);
    // R5: the hit run never reaches the detection count while idle.
    p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < RW'(HOLD));
    // R7: the search index stays inside the window.
    p_search_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scnt_q < SW'(SEARCH));
    // R9: boundary strobes come only from the locked phase.
    p_strobe_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sym_strobe |-> (state_q == ST_LOCK));
    // R10: outside idle no new detection can be raised.
    p_no_redetect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> !frame_det);
endmodule

// File: rtl/psync_top.sv
// Preamble timing synchronizer top.
// Wires the periodicity correlator and the pattern correlator to the
// controller. Every decision is made on the accepted sample itself, and
// the outputs are registered one cycle later.
module psync_top #(
    parameter int               W      = 8,
    parameter int               LAG    = 16,
    parameter int               HOLD   = 8,
    parameter int               SEARCH = 64,
    parameter int               PERIOD = 80,
    parameter logic [2*LAG-1:0] COEF   = 32'hB4E1_2D78
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic signed [W-1:0]             in_re,
    input  logic signed [W-1:0]             in_im,
    input  logic [7:0]                      det_frac,
    input  logic [W+$clog2(LAG):0]          xc_thresh,
    output logic                            frame_det,
    output logic                            sym_strobe,
    output logic signed [2*W+$clog2(LAG):0] acorr_re,
    output logic signed [2*W+$clog2(LAG):0] acorr_im
);
    localparam int LW = $clog2(LAG);
    localparam int AW = 2*W + 1 + LW;
    localparam int MW = W + 1 + LW;

    logic [LAG-1:0][2*W-1:0] hist;
    logic signed [AW-1:0]    a_re_nxt, a_im_nxt;
    logic [AW-1:0]           e_nxt;
    logic [MW-1:0]           metric;

    psync_acorr #(.W(W), .LAG(LAG)) u_acorr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im), .hist(hist),
        .a_re_nxt(a_re_nxt), .a_im_nxt(a_im_nxt), .e_nxt(e_nxt),
        .a_re_q(acorr_re), .a_im_q(acorr_im)
    );

    psync_xcorr #(.W(W), .LAG(LAG), .COEF(COEF)) u_xcorr (
        .in_re(in_re), .in_im(in_im), .hist(hist), .metric(metric)
    );

    psync_ctrl #(.AW(AW), .MW(MW), .FW(8), .HOLD(HOLD),
                 .SEARCH(SEARCH), .PERIOD(PERIOD)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_re_nxt(a_re_nxt), .a_im_nxt(a_im_nxt), .e_nxt(e_nxt),
        .metric(metric), .det_frac(det_frac), .xc_thresh(xc_thresh),
        .frame_det(frame_det), .sym_strobe(sym_strobe)
    );

    // R9: detection and boundary pulses never share a cycle.
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_det && sym_strobe));
endmodule

// File: tb/psync_top_test.sv
// Self-checking bench: a sample-level model of the requirements is
// compared against the ports on every cycle.
module psync_top_test;
    localparam int W = 8, LAG = 16, HOLD = 8, SEARCH = 64, PERIOD = 80;
    localparam logic [31:0] COEF = 32'hB4E1_2D78;
    localparam int AW = 21, MW = 13, MAXS = 4096;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic signed [W-1:0] in_re = '0, in_im = '0;
    logic [7:0] det_frac = '0;
    logic [MW-1:0] xc_thresh = '0;
    logic frame_det, sym_strobe;
    logic signed [AW-1:0] acorr_re, acorr_im;

    always #10 clk = ~clk;

    psync_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .det_frac(det_frac), .xc_thresh(xc_thresh), .frame_det(frame_det),
        .sym_strobe(sym_strobe), .acorr_re(acorr_re), .acorr_im(acorr_im)
    );

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;
    int hre[MAXS], him[MAXS];
    int ns, mst, mrun, mscnt, mbest, mboff, mpcnt;
    bit mfound, exp_det, exp_stb;
    longint exp_ar, exp_ai;
    string ctx;

    task automatic check(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (sample %0d)", tag, act, exp, ns);
        end
    endtask

    function automatic int sr(int i); return (i < 0) ? 0 : hre[i]; endfunction
    function automatic int si(int i); return (i < 0) ? 0 : him[i]; endfunction

    task automatic model_reset();
        ns = 0; mst = 0; mrun = 0; mscnt = 0; mbest = 0; mboff = 0; mpcnt = 0;
        mfound = 0; exp_ar = 0; exp_ai = 0; exp_det = 0; exp_stb = 0; ctx = "R4 R5";
    endtask

    // Applies one accepted sample to the reference model.
    task automatic model_sample(int re, int im);
        longint ar = 0, ai = 0, en = 0, xr = 0, xi = 0, lhs, rhs;
        int metric, k;
        bit hit, take;
        hre[ns] = re; him[ns] = im;
        for (int i = ns - LAG + 1; i <= ns; i++) begin
            ar += sr(i) * sr(i-LAG) + si(i) * si(i-LAG);
            ai += si(i) * sr(i-LAG) - sr(i) * si(i-LAG);
            en += sr(i) * sr(i) + si(i) * si(i);
        end
        for (int t = 0; t < LAG; t++) begin
            int a = sr(ns - LAG + 1 + t), b = si(ns - LAG + 1 + t);
            case ((COEF >> (2*t)) & 32'd3)
                0: begin xr += a;  xi += b;  end
                1: begin xr += b;  xi -= a;  end
                2: begin xr -= a;  xi -= b;  end
                default: begin xr -= b; xi += a; end
            endcase
        end
        metric = int'((xr < 0 ? -xr : xr) + (xi < 0 ? -xi : xi));
        lhs = (ar*ar + ai*ai) * 256;
        rhs = longint'(det_frac) * en * en;
        hit = lhs > rhs;
        exp_ar = ar; exp_ai = ai;
        case (mst)
            0: begin
                ctx = "R4 R5";
                if (!hit) mrun = 0;
                else if (mrun + 1 == HOLD) begin
                    exp_det = 1; mst = 1; mrun = 0; mscnt = 0; mfound = 0; mbest = 0; mboff = 0;
                end else mrun++;
            end
            1: begin
                ctx = "R6 R7 R10";
                k = mscnt + 1;
                take = (metric > int'(xc_thresh)) && (!mfound || metric > mbest);
                if (take) begin mbest = metric; mboff = k; mfound = 1; end
                if (k == SEARCH) begin
                    mscnt = 0;
                    if (mfound) begin mst = 2; mpcnt = mboff + PERIOD - SEARCH; end
                    else begin mst = 0; ctx = "R8"; end
                end else mscnt = k;
            end
            default: begin
                ctx = "R9 R10";
                if (mpcnt == 1) begin exp_stb = 1; mpcnt = PERIOD; end
                else mpcnt--;
            end
        endcase
        ns++;
    endtask

    // Drives one cycle, then checks all outputs half a period after the edge.
    task automatic step(bit v, int re, int im);
        in_valid = v; in_re = W'(re); in_im = W'(im);
        @(posedge clk);
        @(negedge clk);
        exp_det = 0; exp_stb = 0;
        if (v) model_sample(re, im);
        check(v ? "R2 acorr_re" : "R3 acorr_re held", longint'(acorr_re), exp_ar);
        check(v ? "R2 acorr_im" : "R3 acorr_im held", longint'(acorr_im), exp_ai);
        check({ctx, " frame_det"}, longint'(frame_det), longint'(exp_det));
        check({ctx, " sym_strobe"}, longint'(sym_strobe), longint'(exp_stb));
    endtask

    task automatic do_reset();
        rst_n = 0; in_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        check("R1 frame_det", longint'(frame_det), 0);
        check("R1 sym_strobe", longint'(sym_strobe), 0);
        check("R1 acorr_re", longint'(acorr_re), 0);
        check("R1 acorr_im", longint'(acorr_im), 0);
    endtask

    function automatic int noise(int amp);
        return int'($urandom_range(2*amp)) - amp;
    endfunction

    // Sample k of the stored pattern, scaled by amp (code 0:+1 1:+j 2:-1 3:-j).
    function automatic int pat_re(int k, int amp);
        case ((COEF >> (2*k)) & 32'd3) 0: return amp; 2: return -amp; default: return 0; endcase
    endfunction
    function automatic int pat_im(int k, int amp);
        case ((COEF >> (2*k)) & 32'd3) 1: return amp; 3: return -amp; default: return 0; endcase
    endfunction

    initial begin
        int prr[LAG], pri[LAG];
        void'($urandom(32'd7301));

        // Noise with gaps: running sums and idle cycles (R2, R3).
        do_reset();
        det_frac = 8'd200; xc_thresh = 13'd4000;
        for (int i = 0; i < 300; i++) step($urandom_range(3) != 0, noise(60), noise(60));

        // Matching preamble: detect, lock, ignore later hits (R4-R7, R9, R10).
        do_reset();
        det_frac = 8'd230; xc_thresh = 13'd1200;
        for (int i = 0; i < 20; i++) step(1, 0, 0);
        for (int r = 0; r < 12; r++)
            for (int k = 0; k < LAG; k++) step(1, pat_re(k, 100), pat_im(k, 100));
        for (int i = 0; i < 200; i++) step($urandom_range(4) != 0, noise(30), noise(30));
        for (int r = 0; r < 10; r++)
            for (int k = 0; k < LAG; k++) step(1, pat_re(k, 100), pat_im(k, 100));

        // Periodic but unmatched with an unreachable threshold: fail, re-detect (R8).
        do_reset();
        det_frac = 8'd230; xc_thresh = 13'd8191;
        for (int k = 0; k < LAG; k++) begin prr[k] = noise(50); pri[k] = noise(50); end
        for (int r = 0; r < 20; r++)
            for (int k = 0; k < LAG; k++) step(1, prr[k], pri[k]);

        // Peak on the last search sample (R7, R9).
        do_reset();
        det_frac = 8'd230; xc_thresh = 13'd1500;
        for (int k = 0; k < LAG; k++) begin prr[k] = noise(40); pri[k] = noise(40); end
        for (int i = 0; i < 400 && mst == 0; i++) step(1, prr[i % LAG], pri[i % LAG]);
        for (int i = 0; i < SEARCH - LAG; i++) step(1, 0, 0);
        for (int k = 0; k < LAG; k++) step(1, pat_re(k, 100), pat_im(k, 100));
        check("R7 peak on last window sample", longint'(mboff), longint'(SEARCH));
        for (int i = 0; i < 200; i++) step(1, noise(20), noise(20));

        // Random mix of noise and preamble bursts with random thresholds.
        for (int run = 0; run < 3; run++) begin
            do_reset();
            det_frac = 8'(180 + $urandom_range(70));
            xc_thresh = 13'(900 + $urandom_range(800));
            while (ns < 900) begin
                if ($urandom_range(1) == 0) begin
                    for (int i = 0; i < 20 + int'($urandom_range(60)); i++)
                        step($urandom_range(6) != 0, noise(50), noise(50));
                end else begin
                    int amp = 60 + int'($urandom_range(50));
                    for (int r = 0; r < 3 + int'($urandom_range(8)); r++)
                        for (int k = 0; k < LAG; k++)
                            step($urandom_range(6) != 0, pat_re(k, amp), pat_im(k, amp));
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule